// File: doc/BRIEF.md
# Inbound Streaming Word Buffer with Delayed Fullness Flags

This block is the receiving end of a synchronous streaming port. A host master pushes 32-bit words into it on any clock where its write strobe is high. A message may arrive as one unbroken burst, or with idle gaps of any length between words. The words go into a 64-entry FIFO, and a downstream engine drains them through a pop port that sees an undelayed empty indication.

The host paces itself from three fullness flags: empty, full, and "occupancy above a programmable threshold". These flags are pipelined, so they lag the true occupancy by a fixed three cycles. The host has to leave headroom for words already in flight. A write into a full buffer is an overflow. The word is dropped, a sticky status bit is set, and, when enabled, an interrupt is raised. The buffer then freezes in an error state until software writes the reset bit of its control register.

A small register write port sets the threshold, the interrupt enable and the self-clearing reset bit.

Top module: `stream_ingress_buffer`

## Requirements
- R1: After the synchronous reset `level_flags` is 3'b001 (only the empty flag set), `ovf_status` and `irq` are 0, and `rd_empty` is 1.
- R2: Words leave in the order they were written. A pop accepted at a clock edge presents the popped word on `rd_data` from that edge on.
- R3: Every word with `wr_en` high is stored and no other word is, whether writes are contiguous or separated by idle cycles.
- R4: `level_flags[0]` is set when 0 words are stored and `level_flags[2]` when 64 are stored. `level_flags[1]` is set when the stored count exceeds the threshold, i.e. free space is below 64 minus the threshold. The threshold is `cfg_wdata[6:0]` written with `cfg_addr`=0, and resets to 32.
- R5: A write sampled at clock edge k is reflected in `level_flags` only after edge k+3, and the flags still hold the previous value after edge k+2.
- R6: A write while 64 words are stored is discarded and sets `ovf_status`, which stays set. The control register is written with `cfg_addr`=1, and its bit 0 is the interrupt enable. When that bit is 1, `irq` goes high the cycle after `ovf_status`; when it is 0, `irq` stays low.
- R7: While `ovf_status` is set, writes and pops are ignored and the stored count does not change. Writing control bit 1 as 1 clears the count, the pointers, `ovf_status` and `irq`, leaving the interrupt enable as written in that same access.
- R8: A pop while the buffer is empty is ignored: `rd_data` holds and `rd_empty` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 threshold, 1 control |
| cfg_wdata | input | 8 | Register write data |
| level_flags | output | 3 | Delayed flags: bit0 empty, bit1 above threshold, bit2 full |
| ovf_status | output | 1 | Sticky overflow status |
| irq | output | 1 | Overflow interrupt, gated by enable |
| pop | input | 1 | Consumer pop request |
| rd_data | output | 32 | Word most recently popped |
| rd_empty | output | 1 | Undelayed empty indication for the consumer |

## Verification
A table of threshold and fill-count pairs drives the buffer to zero, one, threshold, threshold plus one, 63 and 64 words, with writes broken by idle gaps. This shows whether the threshold compare is strict and whether the empty and full decodes fire at the right counts. A single write followed by samples two and three edges later separates the correct three-cycle lag from one that is a cycle short or a cycle long. Overflow is tried both with and without the interrupt enable. Pops issued during the error state and after a soft reset show whether the freeze holds and whether the pointers are usable again. Popping a known sequence and then popping once more on empty checks both ordering and the ignored-pop rule.

// File: rtl/stream_in_pkg.sv
package stream_in_pkg;
  localparam int FLAG_EMPTY = 0;
  localparam int FLAG_MARK  = 1;
  localparam int FLAG_FULL  = 2;
  localparam int NUM_FLAGS  = 3;
  localparam logic CFG_THRESH = 1'b0;
  localparam logic CFG_CTRL   = 1'b1;
  localparam int CTRL_IRQ_EN  = 0;
  localparam int CTRL_CLEAR   = 1;
endpackage

// File: rtl/sib_cfg_regs.sv
module sib_cfg_regs
  import stream_in_pkg::*;
#(
  parameter int CW = 7,
  parameter int THR_RESET = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [CW-1:0] thresh,
  output logic          irq_en,
  output logic          clr_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thresh    <= CW'(THR_RESET);
      irq_en    <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= 1'b0;
      if (cfg_we) begin
        if (cfg_addr == CFG_THRESH) begin
          thresh <= cfg_wdata[CW-1:0];
        end else begin
          irq_en    <= cfg_wdata[CTRL_IRQ_EN];
          clr_pulse <= cfg_wdata[CTRL_CLEAR];
        end
      end
    end
  end

  p_clear_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    clr_pulse && !(cfg_we && cfg_addr == CFG_CTRL) |=> !clr_pulse);
endmodule

// File: rtl/sib_store.sv
module sib_store #(
  parameter int W = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          err
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, ovf_now, wr_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign ovf_now = wr_en && full && !err && !clr;
  assign wr_ok   = wr_en && !full && !err && !clr;
  assign pop_ok  = pop && !empty && !err && !clr && !ovf_now;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      err   <= 1'b0;
    end else begin
      if (ovf_now) err <= 1'b1;
      if (wr_ok) wptr <= wptr + 1'b1;
      if (pop_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err && !clr |=> err);
  p_err_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    err && !clr |=> $stable(count));
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !clr |=> $stable(rd_data));
endmodule

// File: rtl/sib_level_pipe.sv
module sib_level_pipe
  import stream_in_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LAG_STAGES = 2,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int FW = NUM_FLAGS * LAG_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        count,
  input  logic [CW-1:0]        thresh,
  output logic [NUM_FLAGS-1:0] level_flags
);
  localparam logic [NUM_FLAGS-1:0] IDLE_FLAGS = NUM_FLAGS'(1 << FLAG_EMPTY);

  logic [NUM_FLAGS-1:0]    raw_q;
  logic [FW-1:0]           dly;
  logic [FW+NUM_FLAGS-1:0] chain;
  logic [1:0]              since_rst;

  assign chain = {dly, raw_q};
  assign level_flags = dly[FW-1 -: NUM_FLAGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= IDLE_FLAGS;
      dly   <= {LAG_STAGES{IDLE_FLAGS}};
    end else begin
      raw_q[FLAG_EMPTY] <= (count == '0);
      raw_q[FLAG_MARK]  <= (count > thresh);
      raw_q[FLAG_FULL]  <= (count == CW'(DEPTH));
      dly <= chain[FW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  p_lag_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) && (LAG_STAGES == 2) |->
      level_flags[FLAG_EMPTY] == ($past(count, 3) == '0));
  p_lag_full_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) && (LAG_STAGES == 2) |->
      level_flags[FLAG_FULL] == ($past(count, 3) == CW'(DEPTH)));
endmodule

// File: rtl/stream_ingress_buffer.sv
module stream_ingress_buffer
  import stream_in_pkg::*;
#(
  parameter int W = 32,
  parameter int DEPTH = 64,
  parameter int LAG_STAGES = 2,
  parameter int THR_RESET = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [W-1:0]         wr_data,
  input  logic                 cfg_we,
  input  logic                 cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [NUM_FLAGS-1:0] level_flags,
  output logic                 ovf_status,
  output logic                 irq,
  input  logic                 pop,
  output logic [W-1:0]         rd_data,
  output logic                 rd_empty
);
  logic [CW-1:0] thresh, count;
  logic          irq_en, clr_pulse;

  sib_cfg_regs #(.CW(CW), .THR_RESET(THR_RESET)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .thresh(thresh), .irq_en(irq_en),
    .clr_pulse(clr_pulse)
  );

  sib_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(clr_pulse), .wr_en(wr_en), .wr_data(wr_data),
    .pop(pop), .rd_data(rd_data), .count(count), .err(ovf_status)
  );

  sib_level_pipe #(.DEPTH(DEPTH), .LAG_STAGES(LAG_STAGES)) u_level (
    .clk(clk), .rst(rst), .count(count), .thresh(thresh),
    .level_flags(level_flags)
  );

  assign rd_empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst || clr_pulse) irq <= 1'b0;
    else irq <= ovf_status && irq_en;
  end

  p_irq_raise_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_status && irq_en && !clr_pulse |=> irq);
  p_irq_needs_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    !ovf_status |=> !irq);
endmodule

// File: tb/sim_stream_ingress_buffer.sv
module sim_stream_ingress_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {threshold[6:0], fill[6:0], expected flags[2:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {7'd30, 7'd0,  3'b001},
    {7'd30, 7'd30, 3'b000},
    {7'd30, 7'd31, 3'b010},
    {7'd0,  7'd1,  3'b010},
    {7'd63, 7'd63, 3'b000},
    {7'd63, 7'd64, 3'b110},
    {7'd64, 7'd64, 3'b100},
    {7'd30, 7'd64, 3'b110}
  };

  logic clk = 0, rst = 1, wr_en = 0, cfg_we = 0, cfg_addr = 0, pop = 0;
  logic [31:0] wr_data = 0;
  logic [7:0] cfg_wdata = 0;
  logic [2:0] level_flags;
  logic ovf_status, irq, rd_empty;
  logic [31:0] rd_data;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_ingress_buffer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .level_flags(level_flags), .ovf_status(ovf_status), .irq(irq),
    .pop(pop), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic soft_clear(input logic en);
    cfg_write(1'b1, {6'd0, 1'b1, en});
    idle(5);
  endtask

  task automatic fill(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = base + i;
      @(negedge clk);
      wr_en = 0;
      if (i % 3 == 2) @(negedge clk);
    end
  endtask

  task automatic pop_one();
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check({29'd0, level_flags}, 32'd1, "R1 flags");
    check({31'd0, ovf_status}, 32'd0, "R1 ovf");
    check({31'd0, irq}, 32'd0, "R1 irq");
    check({31'd0, rd_empty}, 32'd1, "R1 rd_empty");

    // R4 R3 threshold/fill table with paused writes
    for (int v = 0; v < NVEC; v++) begin
      soft_clear(1'b0);
      cfg_write(1'b0, {1'b0, VEC[v][16:10]});
      fill(int'(VEC[v][9:3]), 32'h100);
      idle(4);
      check({29'd0, level_flags}, {29'd0, VEC[v][2:0]}, $sformatf("R4 R3 vec%0d", v));
      check({31'd0, ovf_status}, 32'd0, $sformatf("R3 no ovf vec%0d", v));
    end

    // R5 three-cycle lag
    soft_clear(1'b0);
    cfg_write(1'b0, 8'd0);
    idle(2);
    wr_en = 1; wr_data = 32'hA5;
    @(negedge clk);
    wr_en = 0;
    check({31'd0, rd_empty}, 32'd0, "R5 rd_empty undelayed");
    idle(2);
    check({29'd0, level_flags}, 32'd1, "R5 unchanged after k+2");
    idle(1);
    check({29'd0, level_flags}, 32'd2, "R5 updated after k+3");

    // R2 ordering, R8 pop on empty
    soft_clear(1'b0);
    fill(5, 32'hC0DE_0000);
    for (int i = 0; i < 5; i++) begin
      pop_one();
      check(rd_data, 32'hC0DE_0000 + i, $sformatf("R2 order word%0d", i));
    end
    check({31'd0, rd_empty}, 32'd1, "R2 drained");
    pop_one();
    idle(1);
    check(rd_data, 32'hC0DE_0004, "R8 rd_data held");
    check({31'd0, rd_empty}, 32'd1, "R8 still empty");

    // R6 overflow with interrupt disabled
    soft_clear(1'b0);
    cfg_write(1'b0, 8'd30);
    fill(65, 32'h200);
    idle(3);
    check({31'd0, ovf_status}, 32'd1, "R6 ovf set");
    check({31'd0, irq}, 32'd0, "R6 irq masked");
    // R7 frozen: pops and writes ignored
    pop_one();
    fill(2, 32'h900);
    idle(4);
    check({29'd0, level_flags}, 32'd6, "R7 frozen flags");
    check({31'd0, rd_empty}, 32'd0, "R7 frozen count");
    check({31'd0, ovf_status}, 32'd1, "R6 ovf sticky");
    // R7 soft reset recovery
    soft_clear(1'b0);
    check({29'd0, level_flags}, 32'd1, "R7 flags cleared");
    check({31'd0, ovf_status}, 32'd0, "R7 ovf cleared");
    check({31'd0, rd_empty}, 32'd1, "R7 empty after clear");
    fill(1, 32'h7777);
    pop_one();
    check(rd_data, 32'h7777, "R7 pointers usable");

    // R6 overflow with interrupt enabled
    soft_clear(1'b1);
    fill(65, 32'h300);
    idle(3);
    check({31'd0, irq}, 32'd1, "R6 irq raised");
    soft_clear(1'b1);
    check({31'd0, irq}, 32'd0, "R7 irq cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule